// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit carries out the four single-bit operations of a processor execute stage: test, invert, force-to-zero and force-to-one. Each request names one bit of an operand. The operand is either a full 32-bit data register or one byte fetched from memory. The bit number comes either from an immediate extension word or from a data register. The unit computes three things from the operand value as it stood before the operation:

- the zero flag;
- the rewritten operand;
- a write-back strobe.

It also reports the instruction's base cycle cost and whether an extension word was consumed.

The surrounding pipeline does the rest. It computes addresses, reads the memory byte and presents it on the low eight operand bits. It adds the addressing-mode cycle component to the reported cost. It merges the single zero flag into its condition codes and leaves the other flags alone.

A request is presented for one cycle with `inValid` high. All results are registered and appear together one cycle later, marked by a single-cycle `resValid`.

Top module: `bitMod`

## Requirements
- R1: With `toReg` high, the bit index is `bitNum` modulo 32 and the operation acts on all 32 bits of `operand`.
- R2: With `toReg` low, the bit index is `bitNum` modulo 8 and only `operand[7:0]` is used. `resData[31:8]` is zero.
- R3: `zFlag` is 1 exactly when the addressed bit of the incoming operand is 0. This holds for all four operations.
- R4: `opKind` 01 inverts the addressed bit, 10 clears it and 11 sets it. Every other bit of the (register or byte) operand is passed through unchanged.
- R5: `opKind` 00 (test) keeps `wrEn` low and returns the operand unchanged on `resData`.
- R6: `cycCost` is 10 for an immediate bit number with a register operand and 8 for an immediate bit number with a memory byte. It is 6 for a register-held bit number with a register operand and 4 for a register-held bit number with a memory byte.
- R7: `extWord` is 1 when the bit number is immediate (`bitImm` high) and 0 otherwise.
- R8: Results appear one cycle after `inValid`, with `resValid` high for exactly that cycle. `wrEn` is high only together with `resValid`. The other outputs hold their values between requests.
- R9: During and after reset, every output is zero until the first request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opKind | input | 2 | 00 test, 01 invert, 10 clear, 11 set |
| bitImm | input | 1 | 1: bit number from extension word, 0: from a data register |
| bitNum | input | 32 | Bit number source value |
| operand | input | 32 | Register value, or memory byte in bits 7:0 |
| toReg | input | 1 | 1: register operand, 0: memory byte |
| resValid | output | 1 | Results valid this cycle |
| zFlag | output | 1 | Zero flag from the addressed bit |
| resData | output | 32 | Rewritten operand |
| wrEn | output | 1 | Write-back enable |
| extWord | output | 1 | Extension word consumed |
| cycCost | output | 5 | Base cycle cost, excluding the addressing-mode component |

## Verification
Every result is computed from one registered stage, so all outputs are due exactly one clock after the request cycle. `resValid` and `wrEn` must also be low again one clock after that. The bench drives each request on a falling edge, lowers `inValid` on the next falling edge, and reads all results there. That falling edge comes after the single capturing rising edge. It then samples again one falling edge later to confirm the strobes have dropped and the data has held. The sweep covers:

- all operations;
- both operand kinds;
- both bit-number sources;
- bit numbers 0 to 63, so the modulo wrap is exercised;
- several operand patterns.

// File: rtl/bitModPkg.sv
package bitModPkg;
  localparam int COST_W = 5;

  typedef enum logic [1:0] {
    OP_TEST = 2'b00,
    OP_INV  = 2'b01,
    OP_CLR  = 2'b10,
    OP_SET  = 2'b11
  } bitOpE;

  typedef struct packed {
    logic              wide;
    logic              doInv;
    logic              doClr;
    logic              doSet;
    logic              wrBack;
    logic              ext;
    logic [COST_W-1:0] cost;
  } bitCtrlS;
endpackage

// File: rtl/bitModCtrl.sv
module bitModCtrl
  import bitModPkg::*;
#(
  parameter int COST_IMM_REG = 10,
  parameter int COST_IMM_MEM = 8,
  parameter int COST_DR_REG  = 6,
  parameter int COST_DR_MEM  = 4
) (
  input  logic [1:0] opKind,
  input  logic       bitImm,
  input  logic       toReg,
  output bitCtrlS    ctrl
);
  bitOpE op;
  assign op = bitOpE'(opKind);

  always_comb begin
    ctrl        = '0;
    ctrl.wide   = toReg;
    ctrl.doInv  = (op == OP_INV);
    ctrl.doClr  = (op == OP_CLR);
    ctrl.doSet  = (op == OP_SET);
    ctrl.wrBack = (op != OP_TEST);
    ctrl.ext    = bitImm;
    unique case ({bitImm, toReg})
      2'b11:   ctrl.cost = COST_W'(COST_IMM_REG);
      2'b10:   ctrl.cost = COST_W'(COST_IMM_MEM);
      2'b01:   ctrl.cost = COST_W'(COST_DR_REG);
      default: ctrl.cost = COST_W'(COST_DR_MEM);
    endcase
  end
endmodule

// File: rtl/bitModPath.sv
module bitModPath
  import bitModPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  bitCtrlS           ctrl,
  input  logic [31:0]       bitNum,
  input  logic [DATA_W-1:0] operand,
  output logic              resValid,
  output logic              zFlag,
  output logic [DATA_W-1:0] resData,
  output logic              wrEn,
  output logic              extWord,
  output logic [COST_W-1:0] cycCost
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int BIDX_W = $clog2(BYTE_W);

  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] newVal;
  logic              zNext;

  assign bitIdx = ctrl.wide ? bitNum[IDX_W-1:0]
                            : {{(IDX_W-BIDX_W){1'b0}}, bitNum[BIDX_W-1:0]};

  for (genvar g = 0; g < DATA_W; g++) begin : g_opnd
    if (g < BYTE_W) begin : g_low
      assign opnd[g] = operand[g];
    end else begin : g_high
      assign opnd[g] = operand[g] & ctrl.wide;
    end
  end

  assign bitMask = {{(DATA_W-1){1'b0}}, 1'b1} << bitIdx;
  assign zNext   = ((opnd & bitMask) == '0);

  always_comb begin
    newVal = opnd;
    if (ctrl.doInv) newVal = opnd ^ bitMask;
    if (ctrl.doClr) newVal = opnd & ~bitMask;
    if (ctrl.doSet) newVal = opnd | bitMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      wrEn     <= 1'b0;
      zFlag    <= 1'b0;
      resData  <= '0;
      extWord  <= 1'b0;
      cycCost  <= '0;
    end else begin
      resValid <= inValid;
      wrEn     <= inValid & ctrl.wrBack;
      if (inValid) begin
        zFlag   <= zNext;
        resData <= newVal;
        extWord <= ctrl.ext;
        cycCost <= ctrl.cost;
      end
    end
  end
endmodule

// File: rtl/bitMod.sv
module bitMod
  import bitModPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        opKind,
  input  logic              bitImm,
  input  logic [31:0]       bitNum,
  input  logic [DATA_W-1:0] operand,
  input  logic              toReg,
  output logic              resValid,
  output logic              zFlag,
  output logic [DATA_W-1:0] resData,
  output logic              wrEn,
  output logic              extWord,
  output logic [4:0]        cycCost
);
  bitCtrlS ctrl;

  bitModCtrl u_ctrl (
    .opKind (opKind),
    .bitImm (bitImm),
    .toReg  (toReg),
    .ctrl   (ctrl)
  );

  bitModPath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .bitNum   (bitNum),
    .operand  (operand),
    .resValid (resValid),
    .zFlag    (zFlag),
    .resData  (resData),
    .wrEn     (wrEn),
    .extWord  (extWord),
    .cycCost  (cycCost)
  );
endmodule

// File: rtl/bitModChk.sv
module bitModChk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        opKind,
  input logic              bitImm,
  input logic [31:0]       bitNum,
  input logic [DATA_W-1:0] operand,
  input logic              toReg,
  input logic              resValid,
  input logic              zFlag,
  input logic [DATA_W-1:0] resData,
  input logic              wrEn,
  input logic [4:0]        cycCost
);
  // R8: result strobe follows the request by one cycle
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    resValid == $past(inValid));

  // R8: write-back only alongside a valid result
  p_wren_with_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> resValid);

  // R5: a test request never writes back
  p_test_no_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && opKind == 2'b00) |-> !wrEn);

  // R2: memory byte results clear the upper bits
  p_mem_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && !toReg) |-> resData[DATA_W-1:8] == '0);

  // R3: zero flag reflects the register bit before modification
  p_zflag_reg_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && toReg) |->
      zFlag == ((($past(operand) >> $past(bitNum[4:0])) & 32'd1) == 32'd0));

  // R6: immediate bit number with register operand costs 10
  p_cost_imm_reg_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && bitImm && toReg) |-> cycCost == 5'd10);

  // R8: outputs hold between requests
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(!inValid) |-> $stable(resData) && $stable(zFlag));
endmodule

bind bitMod bitModChk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opKind   (opKind),
  .bitImm   (bitImm),
  .bitNum   (bitNum),
  .operand  (operand),
  .toReg    (toReg),
  .resValid (resValid),
  .zFlag    (zFlag),
  .resData  (resData),
  .wrEn     (wrEn),
  .cycCost  (cycCost)
);

// File: tb/bitMod_bench.sv
module bitMod_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opKind = '0;
  logic        bitImm = 1'b0;
  logic [31:0] bitNum = '0;
  logic [31:0] operand = '0;
  logic        toReg = 1'b0;
  logic        resValid, zFlag, wrEn, extWord;
  logic [31:0] resData;
  logic [4:0]  cycCost;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  bitMod u_bitMod (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opKind(opKind),
    .bitImm(bitImm), .bitNum(bitNum), .operand(operand), .toReg(toReg),
    .resValid(resValid), .zFlag(zFlag), .resData(resData), .wrEn(wrEn),
    .extWord(extWord), .cycCost(cycCost)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runOne(input logic [1:0] k, input logic imm, input logic reg_,
                        input logic [31:0] bn, input logic [31:0] v);
    int idx;
    logic [31:0] src, m, expD;
    logic expZ;
    @(negedge clk);
    opKind = k; bitImm = imm; toReg = reg_; bitNum = bn; operand = v; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    // expected values: R1 mod 32, R2 mod 8 on byte
    idx  = reg_ ? (bn % 32) : (bn % 8);
    src  = reg_ ? v : (v & 32'hFF);
    m    = 32'd1 << idx;
    expZ = ((src & m) == 0);
    case (k)
      2'b01:   expD = src ^ m;
      2'b10:   expD = src & ~m;
      2'b11:   expD = src | m;
      default: expD = src;
    endcase
    chk("R8 resValid", {31'b0, resValid}, 32'd1);
    chk("R3 zFlag", {31'b0, zFlag}, {31'b0, expZ});
    if (reg_) chk("R1/R4 resData reg", resData, expD);
    else      chk("R2/R4 resData mem", resData, expD);
    if (k == 2'b00) begin
      chk("R5 wrEn test", {31'b0, wrEn}, 32'd0);
      chk("R5 data unchanged", resData, src);
    end else begin
      chk("R4 wrEn", {31'b0, wrEn}, 32'd1);
    end
    chk("R6 cycCost", {27'b0, cycCost},
        imm ? (reg_ ? 32'd10 : 32'd8) : (reg_ ? 32'd6 : 32'd4));
    chk("R7 extWord", {31'b0, extWord}, {31'b0, imm});
    @(negedge clk);
    chk("R8 resValid drop", {31'b0, resValid}, 32'd0);
    chk("R8 wrEn drop", {31'b0, wrEn}, 32'd0);
    chk("R8 hold", resData, expD);
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h0000_0000;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5C3_5A3C;
    pats[3] = 32'h1234_5696;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 resValid", {31'b0, resValid}, 32'd0);
    chk("R9 zFlag", {31'b0, zFlag}, 32'd0);
    chk("R9 resData", resData, 32'd0);
    chk("R9 wrEn", {31'b0, wrEn}, 32'd0);
    chk("R9 cycCost", {27'b0, cycCost}, 32'd0);
    chk("R9 extWord", {31'b0, extWord}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 after release", resData, 32'd0);
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++)
        for (int r = 0; r < 2; r++)
          for (int i = 0; i < 2; i++)
            for (int b = 0; b < 64; b++)
              runOne(k[1:0], i[0], r[0], 32'(b) | (b[0] ? 32'hFFFF_FF00 : 32'h0), pats[p]);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule